// File: doc/BRIEF.md
# Delegated Interrupt Selector

This block is purely combinational. It looks at the six standard machine and supervisor interrupt lines and picks at most one interrupt for the hart to take. It also reports the privilege level that will handle that interrupt. The pending and enable vectors are ANDed together. A delegation vector then splits the result into a machine candidate set and a supervisor candidate set. Each set is gated by an eligibility rule that depends on the current privilege and on the matching global interrupt-enable bit.

When both sets hold an eligible interrupt, the machine set wins. Inside the chosen set a fixed six-way priority picks one bit. The index of that bit is the cause code. The parameter `HAS_SMODE` says whether supervisor mode exists. When it is 0, the delegation vector is treated as all zeros, so every interrupt goes to machine level.

Top module: `intsel_top`

## Requirements
- R1: The machine candidate set is pending AND enabled AND NOT delegated. The supervisor candidate set is pending AND enabled AND delegated. A taken interrupt always has its pending bit and its enable bit set. Its delegation bit is 1 when it goes to supervisor level and 0 when it goes to machine level.
- R2: Machine candidates are eligible in the cases below. Privilege is encoded as user = 2'b00, supervisor = 2'b01 and machine = 2'b11.
  - In machine mode, only when `m_gie_i` is 1.
  - In supervisor mode and in user mode, always.
- R3: Supervisor candidates are never eligible in machine mode. In supervisor mode they are eligible only when `s_gie_i` is 1. In user mode they are always eligible.
- R4: If the eligible machine set is non-empty, it is chosen and `tgt_priv_o` is 2'b11. Otherwise a non-empty eligible supervisor set is chosen and `tgt_priv_o` is 2'b01.
- R5: Inside the chosen set, priority from highest to lowest is: bit 11, bit 3, bit 7, bit 9, bit 1, bit 5.
- R6: When `HAS_SMODE` is 0, the delegation vector has no effect and every interrupt is handled at machine level.
- R7: When no interrupt is eligible, `take_o` is 0, `cause_o` is 0 and `tgt_priv_o` is 2'b00.
- R8: Only bits 1, 3, 5, 7, 9 and 11 take part in selection. Setting any other bit of the three vectors changes no output.
- R9: `cause_o` equals the index of the chosen bit. The bit meanings are:
  - 1: supervisor software
  - 3: machine software
  - 5: supervisor timer
  - 7: machine timer
  - 9: supervisor external
  - 11: machine external

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pend_i | input | W | Pending interrupt vector |
| en_i | input | W | Per-interrupt enable vector |
| deleg_i | input | W | Delegation vector (1 = handled at supervisor level) |
| priv_i | input | 2 | Current privilege (00 user, 01 supervisor, 11 machine) |
| m_gie_i | input | 1 | Machine global interrupt enable |
| s_gie_i | input | 1 | Supervisor global interrupt enable |
| take_o | output | 1 | An interrupt is to be taken |
| cause_o | output | 4 | Bit index of the chosen interrupt |
| tgt_priv_o | output | 2 | Privilege that handles the interrupt |

## Verification
All three outputs are combinational, so each result is due in the same cycle as the inputs that cause it. There is no register anywhere on the path. The bench drives each new vector on the falling edge of its clock and samples the outputs 2 ns later, well before the next rising edge. The stimulus therefore settles before every comparison, and no check depends on the order of events at a clock edge.

// File: rtl/intsel_pkg.sv
package intsel_pkg;

    localparam int STD_W   = 12;
    localparam int CAUSE_W = 4;
    localparam int NUM_SRC = 6;

    typedef enum logic [1:0] {
        PRV_U = 2'b00,
        PRV_S = 2'b01,
        PRV_M = 2'b11
    } prv_e;

    // Bit positions of the six standard sources
    localparam int B_SSW = 1;
    localparam int B_MSW = 3;
    localparam int B_STM = 5;
    localparam int B_MTM = 7;
    localparam int B_SEX = 9;
    localparam int B_MEX = 11;

    localparam logic [STD_W-1:0] STD_MASK = 12'b1010_1010_1010;

    // Priority rank, index 0 is the highest
    localparam int RANK [NUM_SRC] = '{B_MEX, B_MSW, B_MTM, B_SEX, B_SSW, B_STM};

    typedef struct packed {
        logic               hit;
        logic [CAUSE_W-1:0] code;
    } pick_t;

    typedef struct packed {
        logic               take;
        logic [CAUSE_W-1:0] cause;
        prv_e               tgt;
    } decision_t;

    // Walk from lowest to highest rank so the last hit wins
    function automatic pick_t pick_highest(logic [STD_W-1:0] set);
        pick_t r;
        r = '0;
        for (int k = NUM_SRC - 1; k >= 0; k--) begin
            if (set[RANK[k]]) begin
                r.hit  = 1'b1;
                r.code = CAUSE_W'(RANK[k]);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/intsel_split.sv
module intsel_split
    import intsel_pkg::*;
#(
    parameter int W         = 12,
    parameter bit HAS_SMODE = 1'b1
) (
    input  logic [W-1:0]     pend,
    input  logic [W-1:0]     en,
    input  logic [W-1:0]     deleg,
    output logic [STD_W-1:0] m_set,
    output logic [STD_W-1:0] s_set
);
    logic [STD_W-1:0] live;
    logic [STD_W-1:0] dmask;

    assign live = pend[STD_W-1:0] & en[STD_W-1:0] & STD_MASK;

    generate
        if (HAS_SMODE) begin : g_deleg
            assign dmask = deleg[STD_W-1:0];
        end else begin : g_nodeleg
            logic unused_deleg;
            assign unused_deleg = ^deleg;
            assign dmask        = '0;
        end
    endgenerate

    assign m_set = live & ~dmask;
    assign s_set = live & dmask;
endmodule

// File: rtl/intsel_gate.sv
module intsel_gate
    import intsel_pkg::*;
(
    input  logic [1:0] priv,
    input  logic       m_gie,
    input  logic       s_gie,
    output logic       m_ok,
    output logic       s_ok
);
    always_comb begin
        unique case (priv)
            PRV_M:   begin m_ok = m_gie; s_ok = 1'b0;  end
            PRV_S:   begin m_ok = 1'b1;  s_ok = s_gie; end
            default: begin m_ok = 1'b1;  s_ok = 1'b1;  end
        endcase
    end
endmodule

// File: rtl/intsel_pick.sv
module intsel_pick
    import intsel_pkg::*;
(
    input  logic [STD_W-1:0] set,
    output pick_t            sel
);
    assign sel = pick_highest(set);
endmodule

// File: rtl/intsel_top.sv
module intsel_top
    import intsel_pkg::*;
#(
    parameter int W         = 12,
    parameter bit HAS_SMODE = 1'b1
) (
    input  logic [W-1:0]       pend_i,
    input  logic [W-1:0]       en_i,
    input  logic [W-1:0]       deleg_i,
    input  logic [1:0]         priv_i,
    input  logic               m_gie_i,
    input  logic               s_gie_i,
    output logic               take_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic [1:0]         tgt_priv_o
);
    localparam int LVLS = 2;  // 0 = machine, 1 = supervisor

    logic [STD_W-1:0] lvl_set [LVLS];
    pick_t            lvl_pick [LVLS];
    logic             lvl_ok [LVLS];
    decision_t        dec;

    intsel_split #(.W(W), .HAS_SMODE(HAS_SMODE)) u_split (
        .pend  (pend_i),
        .en    (en_i),
        .deleg (deleg_i),
        .m_set (lvl_set[0]),
        .s_set (lvl_set[1])
    );

    intsel_gate u_gate (
        .priv  (priv_i),
        .m_gie (m_gie_i),
        .s_gie (s_gie_i),
        .m_ok  (lvl_ok[0]),
        .s_ok  (lvl_ok[1])
    );

    generate
        for (genvar g = 0; g < LVLS; g++) begin : g_lvl
            intsel_pick u_pick (
                .set (lvl_set[g]),
                .sel (lvl_pick[g])
            );
        end
    endgenerate

    always_comb begin
        dec = '{take: 1'b0, cause: '0, tgt: PRV_U};
        if (lvl_ok[0] && lvl_pick[0].hit) begin
            dec = '{take: 1'b1, cause: lvl_pick[0].code, tgt: PRV_M};
        end else if (lvl_ok[1] && lvl_pick[1].hit) begin
            dec = '{take: 1'b1, cause: lvl_pick[1].code, tgt: PRV_S};
        end
    end

    assign take_o     = dec.take;
    assign cause_o    = dec.cause;
    assign tgt_priv_o = dec.tgt;
endmodule

// File: rtl/intsel_chk.sv
module intsel_chk
    import intsel_pkg::*;
#(
    parameter int W         = 12,
    parameter bit HAS_SMODE = 1'b1
) (
    input logic [W-1:0]       pend_i,
    input logic [W-1:0]       en_i,
    input logic [W-1:0]       deleg_i,
    input logic [1:0]         priv_i,
    input logic               m_gie_i,
    input logic               s_gie_i,
    input logic               take_o,
    input logic [CAUSE_W-1:0] cause_o,
    input logic [1:0]         tgt_priv_o
);
    always_comb begin
        // R1: a taken interrupt is pending and enabled
        p_taken_live_r1: assert (!take_o || (pend_i[cause_o] && en_i[cause_o]));
        // R1: delegation bit agrees with the target level
        p_deleg_side_r1: assert (!take_o || !HAS_SMODE ||
                                 (deleg_i[cause_o] == (tgt_priv_o == PRV_S)));
        // R2: machine mode with the machine enable clear takes nothing
        p_m_gie_r2: assert (!(priv_i == PRV_M && !m_gie_i) || !take_o);
        // R3: never a supervisor target while in machine mode
        p_no_s_in_m_r3: assert (!(priv_i == PRV_M && take_o && tgt_priv_o == PRV_S));
        // R6: without supervisor mode the target is machine
        p_no_smode_r6: assert (HAS_SMODE || !take_o || tgt_priv_o == PRV_M);
        // R7: idle outputs are zero
        p_idle_zero_r7: assert (take_o || (cause_o == '0 && tgt_priv_o == 2'b00));
        // R9: cause is one of the six standard bit positions
        p_std_code_r9: assert (!take_o || (cause_o[0] && cause_o != 4'd13 && cause_o != 4'd15));
    end
endmodule

bind intsel_top intsel_chk #(.W(W), .HAS_SMODE(HAS_SMODE)) u_chk (
    .pend_i     (pend_i),
    .en_i       (en_i),
    .deleg_i    (deleg_i),
    .priv_i     (priv_i),
    .m_gie_i    (m_gie_i),
    .s_gie_i    (s_gie_i),
    .take_o     (take_o),
    .cause_o    (cause_o),
    .tgt_priv_o (tgt_priv_o)
);

// File: tb/tb_intsel_top.sv
`timescale 1ns/1ps
module tb_intsel_top;
    localparam int W = 12;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [W-1:0] pend, en, deleg;
    logic [1:0]   priv;
    logic         mg, sg;
    logic         take_a, take_b;
    logic [3:0]   cause_a, cause_b;
    logic [1:0]   tgt_a, tgt_b;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    intsel_top #(.W(W), .HAS_SMODE(1'b1)) dut (
        .pend_i(pend), .en_i(en), .deleg_i(deleg), .priv_i(priv),
        .m_gie_i(mg), .s_gie_i(sg),
        .take_o(take_a), .cause_o(cause_a), .tgt_priv_o(tgt_a));

    intsel_top #(.W(W), .HAS_SMODE(1'b0)) dut_nos (
        .pend_i(pend), .en_i(en), .deleg_i(deleg), .priv_i(priv),
        .m_gie_i(mg), .s_gie_i(sg),
        .take_o(take_b), .cause_o(cause_b), .tgt_priv_o(tgt_b));

    // Map a 6-bit index onto positions 1,3,5,7,9,11
    function automatic logic [11:0] spread(int v);
        logic [11:0] r = '0;
        for (int k = 0; k < 6; k++) r[2*k+1] = v[k];
        return r;
    endfunction

    // Reference model: returns {take, cause[3:0], tgt[1:0]}
    function automatic logic [6:0] model(logic [11:0] p, logic [11:0] e, logic [11:0] d,
                                         logic [1:0] pr, logic g_m, logic g_s, bit hs);
        int order [6] = '{11, 3, 7, 9, 1, 5};
        logic [11:0] live, dd, ms, ss;
        bit mok, sok;
        live = p & e & 12'hAAA;
        dd   = hs ? d : 12'h000;
        ms   = live & ~dd;
        ss   = live & dd;
        mok  = (pr == 2'b11) ? g_m : 1'b1;
        sok  = (pr == 2'b11) ? 1'b0 : ((pr == 2'b01) ? g_s : 1'b1);
        if (mok && ms != 0)
            for (int k = 0; k < 6; k++) if (ms[order[k]]) return {1'b1, 4'(order[k]), 2'b11};
        if (sok && ss != 0)
            for (int k = 0; k < 6; k++) if (ss[order[k]]) return {1'b1, 4'(order[k]), 2'b01};
        return 7'd0;
    endfunction

    task automatic cmp(string tag, logic [6:0] got, logic [6:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s pend=%h en=%h deleg=%h priv=%0d gie=%b%b got=%h exp=%h",
                     tag, pend, en, deleg, priv, mg, sg, got, exp);
        end
    endtask

    task automatic apply_and_check(string tag, logic [11:0] p, logic [11:0] e,
                                   logic [11:0] d, logic [1:0] pr, logic a, logic b);
        @(negedge clk);
        pend = p; en = e; deleg = d; priv = pr; mg = a; sg = b;
        #2;
        cmp({tag, " smode"},   {take_a, cause_a, tgt_a}, model(p, e, d, pr, a, b, 1'b1));
        cmp({tag, " nosmode"}, {take_b, cause_b, tgt_b}, model(p, e, d, pr, a, b, 1'b0));
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [1:0] privs [3] = '{2'b00, 2'b01, 2'b11};
        pend = '0; en = '0; deleg = '0; priv = 2'b11; mg = 1'b0; sg = 1'b0;
        @(negedge clk); #2;
        // R7: all-zero inputs leave the block idle
        cmp("R7 idle", {take_a, cause_a, tgt_a}, 7'd0);

        // Directed corners
        // R9: a lone machine external maps to cause 11
        apply_and_check("R9 mext",  12'h800, 12'hFFF, 12'h000, 2'b11, 1'b1, 1'b0);
        // R5: machine software outranks machine timer
        apply_and_check("R5 msw",   12'h088, 12'hFFF, 12'h000, 2'b11, 1'b1, 1'b0);
        // R3: a delegated interrupt is not taken in machine mode
        apply_and_check("R3 sinm",  12'h200, 12'hFFF, 12'h200, 2'b11, 1'b1, 1'b1);
        // R2: a machine interrupt is taken from user mode with the enables clear
        apply_and_check("R2 mfromu",12'h080, 12'hFFF, 12'h000, 2'b00, 1'b0, 1'b0);
        // R4: machine set outranks a higher-ranked delegated supervisor bit
        apply_and_check("R4 mwin",  12'h820, 12'hFFF, 12'h800, 2'b00, 1'b0, 1'b0);
        // R6: delegation is ignored without supervisor mode
        apply_and_check("R6 deleg", 12'h002, 12'hFFF, 12'hFFF, 2'b01, 1'b1, 1'b1);
        // R8: only non-standard bits set, nothing is taken
        apply_and_check("R8 junk",  12'h555, 12'hFFF, 12'h555, 2'b00, 1'b1, 1'b1);
        // R8: non-standard bits do not change a live decision
        apply_and_check("R8 mixed", 12'h557, 12'h555 | 12'h002, 12'h000, 2'b00, 1'b0, 1'b0);

        // R1 R2 R3 R4 R5: sweep pending x delegation x privilege x global enables
        for (int pi = 0; pi < 64; pi++)
            for (int di = 0; di < 64; di++)
                for (int pv = 0; pv < 3; pv++)
                    for (int g = 0; g < 4; g++)
                        apply_and_check("R1 R2 R3 R4 R5 sweep", spread(pi), 12'hFFF, spread(di),
                                        privs[pv], g[1], g[0]);

        // R1: enable masking sweep
        for (int ei = 0; ei < 64; ei++)
            for (int di = 0; di < 64; di++)
                for (int pv = 0; pv < 3; pv++)
                    apply_and_check("R1 enable sweep", 12'hFFF, spread(ei), spread(di),
                                    privs[pv], 1'b1, 1'b1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule